// File: doc/BRIEF.md
# Demand-Priority Nibble Link Adapter

This block joins a byte-oriented frame controller to a 4-bit media-independent interface that carries a demand-priority protocol. On the transmit side it splits each byte into two nibbles and sends the low nibble first, with transmit enable held high for the whole frame. Between frames the same four data lines carry the controller's request state: one bit asks for the channel and another bit gives the priority wanted. A per-byte error flag lets the controller push a coding error onto the wire for the nibbles of that byte.

On the receive side the adapter watches data bit 1 in the cycle just before receive-data-valid rises and keeps that value as the frame's priority. It then packs the incoming nibbles into bytes, low nibble first, and raises a byte strobe on every second nibble. When valid falls it reports one end-of-frame pulse. That pulse carries the priority, a coding-error flag that collects the receive error input over the whole frame, and a dribble flag for frames with an odd nibble count. The two sides run on separate clocks, each supplied by the PHY, and each has its own reset.

Top module: `dpmii_link`

## Requirements
- R1: While transmit enable is low, the transmit data lines show the request state registered one transmit clock earlier: bit 0 = ftx_req, bit 1 = ftx_hipri, bits 3:2 = 0. Transmit error is 0. After reset, transmit enable is 0 and the data lines are 0.
- R2: A byte accepted at a transmit clock edge appears at the next two edges with transmit enable high: first the low nibble (data bits 3:0), then the high nibble (data bits 7:4).
- R3: If the next byte is valid in the high-nibble cycle of a byte that is not last, it follows with no gap. After the high nibble of a byte marked last, transmit enable is low for at least one cycle.
- R4: Transmit error is high on both nibble cycles of a byte that was accepted with ftx_err set, and low on the nibbles of any other byte.
- R5: ftx_ack is high in a cycle exactly when ftx_valid is high and either no frame is on the wire, or the high nibble of a byte not marked last is on the wire.
- R6: A received frame's priority is the value of receive data bit 1 in the cycle before receive-data-valid rises. Bit 1 during the frame is ignored. The priority is reported on frx_pri with the end pulse.
- R7: Received nibbles are paired in arrival order, the first of each pair giving byte bits 3:0. frx_valid pulses for one receive clock, one cycle after the second nibble of each pair.
- R8: frx_coderr is high with the end pulse if the receive error input was high in any cycle of the frame while valid was high.
- R9: frx_dribble is high with the end pulse exactly when the frame had an odd number of nibbles. The unpaired last nibble yields no byte strobe.
- R10: frx_end pulses for one receive clock, one cycle after receive-data-valid falls. frx_pri, frx_coderr and frx_dribble are 0 whenever frx_end is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock from the PHY |
| tx_rst_n | input | 1 | Transmit-side asynchronous reset, active low |
| ftx_req | input | 1 | Controller wants to send a frame |
| ftx_hipri | input | 1 | Requested priority (1 = high) |
| ftx_valid | input | 1 | A transmit byte is offered |
| ftx_data | input | 8 | Offered transmit byte |
| ftx_last | input | 1 | Offered byte ends the frame |
| ftx_err | input | 1 | Send the offered byte with a coding error |
| ftx_ack | output | 1 | Offered byte is taken at the next edge |
| mii_txen | output | 1 | Transmit enable |
| mii_txd | output | 4 | Transmit nibble or request state |
| mii_txer | output | 1 | Transmit coding error |
| rx_clk | input | 1 | Receive clock from the PHY |
| rx_rst_n | input | 1 | Receive-side asynchronous reset, active low |
| mii_rxdv | input | 1 | Receive data valid |
| mii_rxd | input | 4 | Receive nibble |
| mii_rxer | input | 1 | Receive coding error |
| frx_valid | output | 1 | Received byte strobe |
| frx_data | output | 8 | Received byte |
| frx_end | output | 1 | End-of-frame pulse |
| frx_pri | output | 1 | Frame priority, with frx_end |
| frx_coderr | output | 1 | Coding error seen in the frame, with frx_end |
| frx_dribble | output | 1 | Odd nibble count, with frx_end |

## Verification
The assertions assume that receive-data-valid is low for at least one cycle between frames, so that every rising edge opens a new frame. They also assume that every input changes only away from the edge of its own clock. The bench drives each side one time unit after its own rising edge, keeps valid low for several cycles between frames, and makes the bit-1 value in the cycle before a frame the opposite of the bit-1 values inside the frame. A wrong sampling point therefore shows up on frx_pri.

// File: rtl/dpmii_pkg.sv
package dpmii_pkg;
  localparam int NIB_W   = 4;
  localparam int BYTE_W  = 2 * NIB_W;
  localparam int REQ_BIT = 0;
  localparam int PRI_BIT = 1;

  // request state shown on the data lines between frames
  function automatic logic [NIB_W-1:0] idle_code(input logic req, input logic pri);
    logic [NIB_W-1:0] c;
    c = '0;
    c[REQ_BIT] = req;
    c[PRI_BIT] = pri;
    return c;
  endfunction

  function automatic logic [NIB_W-1:0] low_nib(input logic [BYTE_W-1:0] b);
    return b[NIB_W-1:0];
  endfunction

  function automatic logic [NIB_W-1:0] high_nib(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:NIB_W];
  endfunction

  function automatic logic [BYTE_W-1:0] join_nibs(input logic [NIB_W-1:0] hi,
                                                  input logic [NIB_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/dpmii_tx.sv
module dpmii_tx
  import dpmii_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              hipri,
  input  logic              valid,
  input  logic [BYTE_W-1:0] data,
  input  logic              last,
  input  logic              err,
  output logic              ack,
  output logic              txen,
  output logic [NIB_W-1:0]  txd,
  output logic              txer
);
  logic             busy, lo_on, hold_last, hold_err;
  logic [NIB_W-1:0] hold_hi;

  // named events
  logic take, send_hi, go_idle;
  assign take    = valid && (!busy || (!lo_on && !hold_last));
  assign send_hi = !take && busy && lo_on;
  assign go_idle = !take && !send_hi;
  assign ack     = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; lo_on <= 1'b0; hold_last <= 1'b0; hold_err <= 1'b0;
      hold_hi <= '0; txen <= 1'b0; txd <= '0; txer <= 1'b0;
    end else if (take) begin
      busy      <= 1'b1;
      lo_on     <= 1'b1;
      hold_hi   <= high_nib(data);
      hold_last <= last;
      hold_err  <= err;
      txen      <= 1'b1;
      txd       <= low_nib(data);
      txer      <= err;
    end else if (send_hi) begin
      lo_on <= 1'b0;
      txd   <= hold_hi;
      txer  <= hold_err;
    end else begin
      busy      <= 1'b0;
      lo_on     <= 1'b0;
      hold_last <= 1'b0;
      txen      <= 1'b0;
      txd       <= idle_code(req, hipri);
      txer      <= 1'b0;
    end
  end

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txen |-> (txd[NIB_W-1:2] == '0 && !txer));
  // R2
  two_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen) |=> txen);
  // R2
  low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (txen && txd == low_nib($past(data))));
  // R4
  err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_hi |=> (txer == $past(txer)));
endmodule

// File: rtl/dpmii_rx.sv
module dpmii_rx
  import dpmii_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dv,
  input  logic [NIB_W-1:0]  rxd,
  input  logic              rxer,
  output logic              bvalid,
  output logic [BYTE_W-1:0] bdata,
  output logic              fend,
  output logic              fpri,
  output logic              fcoderr,
  output logic              fdribble
);
  logic             dv_q, pre_pri, frame_pri, half, err_acc;
  logic [NIB_W-1:0] lo_q;

  // named events
  logic sof, eof, byte_done;
  assign sof       = dv && !dv_q;
  assign eof       = !dv && dv_q;
  assign byte_done = dv && !sof && half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q <= 1'b0; pre_pri <= 1'b0; frame_pri <= 1'b0; half <= 1'b0;
      err_acc <= 1'b0; lo_q <= '0; bvalid <= 1'b0; bdata <= '0;
      fend <= 1'b0; fpri <= 1'b0; fcoderr <= 1'b0; fdribble <= 1'b0;
    end else begin
      dv_q     <= dv;
      pre_pri  <= rxd[PRI_BIT];
      bvalid   <= 1'b0;
      fend     <= 1'b0;
      fpri     <= 1'b0;
      fcoderr  <= 1'b0;
      fdribble <= 1'b0;
      if (sof) begin
        frame_pri <= pre_pri;
        err_acc   <= rxer;
        lo_q      <= rxd;
        half      <= 1'b1;
      end else if (dv) begin
        err_acc <= err_acc | rxer;
        if (byte_done) begin
          bvalid <= 1'b1;
          bdata  <= join_nibs(rxd, lo_q);
          half   <= 1'b0;
        end else begin
          lo_q <= rxd;
          half <= 1'b1;
        end
      end else if (eof) begin
        fend     <= 1'b1;
        fpri     <= frame_pri;
        fcoderr  <= err_acc;
        fdribble <= half;
        half     <= 1'b0;
        err_acc  <= 1'b0;
      end
    end
  end

  // R7
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |=> !bvalid);
  // R7
  first_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !bvalid);
  // R10
  end_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fend |-> !$past(dv));
  // R10
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fend |-> !(fpri || fcoderr || fdribble));
endmodule

// File: rtl/dpmii_link.sv
module dpmii_link
  import dpmii_pkg::*;
(
  input  logic              tx_clk,
  input  logic              tx_rst_n,
  input  logic              ftx_req,
  input  logic              ftx_hipri,
  input  logic              ftx_valid,
  input  logic [BYTE_W-1:0] ftx_data,
  input  logic              ftx_last,
  input  logic              ftx_err,
  output logic              ftx_ack,
  output logic              mii_txen,
  output logic [NIB_W-1:0]  mii_txd,
  output logic              mii_txer,
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  input  logic              mii_rxdv,
  input  logic [NIB_W-1:0]  mii_rxd,
  input  logic              mii_rxer,
  output logic              frx_valid,
  output logic [BYTE_W-1:0] frx_data,
  output logic              frx_end,
  output logic              frx_pri,
  output logic              frx_coderr,
  output logic              frx_dribble
);
  dpmii_tx u_tx (
    .clk(tx_clk), .rst_n(tx_rst_n), .req(ftx_req), .hipri(ftx_hipri),
    .valid(ftx_valid), .data(ftx_data), .last(ftx_last), .err(ftx_err),
    .ack(ftx_ack), .txen(mii_txen), .txd(mii_txd), .txer(mii_txer)
  );

  dpmii_rx u_rx (
    .clk(rx_clk), .rst_n(rx_rst_n), .dv(mii_rxdv), .rxd(mii_rxd),
    .rxer(mii_rxer), .bvalid(frx_valid), .bdata(frx_data), .fend(frx_end),
    .fpri(frx_pri), .fcoderr(frx_coderr), .fdribble(frx_dribble)
  );
endmodule

// File: tb/dpmii_link_tb.sv
module dpmii_link_tb;
  import dpmii_pkg::*;

  logic tx_clk = 0, rx_clk = 0, tx_rst_n = 0, rx_rst_n = 0;
  logic ftx_req = 0, ftx_hipri = 0, ftx_valid = 0, ftx_last = 0, ftx_err = 0;
  logic [7:0] ftx_data = 0;
  logic ftx_ack, mii_txen, mii_txer;
  logic [3:0] mii_txd;
  logic mii_rxdv = 0, mii_rxer = 0;
  logic [3:0] mii_rxd = 0;
  logic frx_valid, frx_end, frx_pri, frx_coderr, frx_dribble;
  logic [7:0] frx_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 tx_clk = ~tx_clk;
  initial begin #3; forever #4 rx_clk = ~rx_clk; end

  dpmii_link u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- transmit scenarios ----------------
  task automatic tx_idle(input bit rq, input bit pr);
    @(posedge tx_clk); #1; ftx_req = rq; ftx_hipri = pr;
    @(posedge tx_clk); @(negedge tx_clk);
    chk(!mii_txen && !mii_txer, "R1 idle enable/error", {mii_txen, mii_txer}, 0);
    chk(mii_txd == {2'b00, pr, rq}, "R1 idle code", mii_txd, {2'b00, pr, rq});
  endtask

  task automatic tx_frame(input logic [7:0] b [], input logic [7:0] emask);
    int n = b.size();
    @(posedge tx_clk); #1;
    ftx_valid = 1; ftx_data = b[0]; ftx_last = (n == 1); ftx_err = emask[0];
    @(negedge tx_clk);
    chk(ftx_ack, "R5 ack when idle", ftx_ack, 1);
    for (int i = 0; i < n; i++) begin
      @(posedge tx_clk); #1; ftx_valid = 0;
      @(negedge tx_clk);
      chk(mii_txen && mii_txd == b[i][3:0], "R2 low nibble", {mii_txen, mii_txd}, {1'b1, b[i][3:0]});
      chk(mii_txer == emask[i], "R4 error low nibble", mii_txer, emask[i]);
      chk(!ftx_ack, "R5 no ack on low nibble", ftx_ack, 0);
      @(posedge tx_clk); #1;
      if (i < n - 1) begin
        ftx_valid = 1; ftx_data = b[i+1]; ftx_last = (i + 1 == n - 1); ftx_err = emask[i+1];
      end else begin
        ftx_valid = 1; ftx_data = 8'hEE; ftx_last = 0; ftx_err = 0;
      end
      @(negedge tx_clk);
      chk(mii_txen && mii_txd == b[i][7:4], "R2 high nibble", {mii_txen, mii_txd}, {1'b1, b[i][7:4]});
      chk(mii_txer == emask[i], "R4 error high nibble", mii_txer, emask[i]);
      chk(ftx_ack == (i < n - 1), "R5 ack on high nibble", ftx_ack, (i < n - 1));
    end
    @(posedge tx_clk); #1; ftx_valid = 0; ftx_err = 0; ftx_last = 0;
    @(negedge tx_clk);
    chk(!mii_txen && mii_txd == {2'b00, ftx_hipri, ftx_req} && !mii_txer, "R3 gap after last",
        {mii_txen, mii_txd}, {1'b0, 2'b00, ftx_hipri, ftx_req});
  endtask

  // ---------------- receive scenarios ----------------
  task automatic rx_frame(input bit pr, input logic [3:0] nib [], input int er_at);
    int n = nib.size();
    logic [7:0] byt;
    @(posedge rx_clk); #1;
    mii_rxdv = 0; mii_rxer = 0; mii_rxd = pr ? 4'b0010 : 4'b1101;
    for (int j = 0; j < n; j++) begin
      @(posedge rx_clk); #1;
      mii_rxdv = 1; mii_rxd = pr ? (nib[j] & 4'hD) : (nib[j] | 4'h2);
      mii_rxer = (j == er_at);
      @(negedge rx_clk);
      if (j >= 2 && j % 2 == 0) begin
        byt = {(pr ? (nib[j-1] & 4'hD) : (nib[j-1] | 4'h2)), (pr ? (nib[j-2] & 4'hD) : (nib[j-2] | 4'h2))};
        chk(frx_valid && frx_data == byt, "R7 byte strobe", {frx_valid, frx_data}, {1'b1, byt});
      end else begin
        chk(!frx_valid, "R7 no strobe", frx_valid, 0);
      end
      chk(!frx_end, "R10 no end during frame", frx_end, 0);
    end
    @(posedge rx_clk); #1; mii_rxdv = 0; mii_rxer = 0; mii_rxd = 0;
    @(negedge rx_clk);
    if (n % 2 == 0) begin
      byt = {(pr ? (nib[n-1] & 4'hD) : (nib[n-1] | 4'h2)), (pr ? (nib[n-2] & 4'hD) : (nib[n-2] | 4'h2))};
      chk(frx_valid && frx_data == byt, "R7 final byte", {frx_valid, frx_data}, {1'b1, byt});
    end else begin
      chk(!frx_valid, "R9 unpaired nibble gives no strobe", frx_valid, 0);
    end
    chk(!frx_end, "R10 end not early", frx_end, 0);
    @(negedge rx_clk);
    chk(frx_end, "R10 end pulse", frx_end, 1);
    chk(frx_pri == pr, "R6 priority before valid", frx_pri, pr);
    chk(frx_coderr == (er_at >= 0 && er_at < n), "R8 coding error", frx_coderr, (er_at >= 0 && er_at < n));
    chk(frx_dribble == (n % 2), "R9 dribble", frx_dribble, n % 2);
    @(negedge rx_clk);
    chk(!frx_end && !frx_pri && !frx_coderr && !frx_dribble, "R10 status quiet",
        {frx_end, frx_pri, frx_coderr, frx_dribble}, 0);
  endtask

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    done = 1;
  end

  initial begin
    logic [7:0] f1 [] = '{8'hA5};
    logic [7:0] f2 [] = '{8'h3C, 8'h7E, 8'h91};
    logic [3:0] r1 [] = '{4'h1, 4'h8, 4'hC, 4'h4};
    logic [3:0] r2 [] = '{4'h9, 4'h5, 4'hF};
    logic [3:0] r3 [] = '{4'h0, 4'hB};
    #2;
    @(negedge tx_clk);
    chk(!mii_txen && mii_txd == 0 && !mii_txer, "R1 reset state", {mii_txen, mii_txd}, 0);
    chk(!frx_valid && !frx_end, "R10 reset state", {frx_valid, frx_end}, 0);
    #10; tx_rst_n = 1; rx_rst_n = 1;
    tx_idle(1, 0);
    tx_idle(1, 1);
    tx_idle(0, 1);
    tx_idle(0, 0);
    ftx_req = 1; ftx_hipri = 1;
    tx_frame(f1, 8'h00);
    tx_frame(f2, 8'h02);
    tx_frame(f2, 8'h05);
    rx_frame(1, r1, -1);
    rx_frame(0, r1, 3);
    rx_frame(1, r2, 0);
    rx_frame(0, r3, -1);
    repeat (3) @(posedge rx_clk);
    done = 1;
  end

  initial begin
    wait (done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule